// File: doc/BRIEF.md
# Transform Input Buffer Controller

This block sits in front of a block-transform engine. Complex samples arrive on a serial stream, one 8-bit in-phase and one 8-bit quadrature value per clock, while a write-valid strobe is high. The block writes them across eight parallel buffer banks so that the engine can later fetch eight samples in a single cycle. A 2-bit mode code picks a 128-sample frame or a 32-sample frame. The block counts accepted samples and raises a one-cycle pulse when a frame is complete. The next frame may start on the very next clock.

Two control tasks run beside the stream. A clear pulse zeroes every bank over 16 cycles, one row per cycle across all banks at once, and ends with a done pulse. A kill pulse returns every counter and handshake to idle on the next edge. The engine reads the banks through a second, combinational port. It presents one row address and gets all eight bank words together.

Top module: `xfrm_inbuf`

## Requirements
- R1: After reset, `frame_ready`, `frame_short`, `clear_busy` and `clear_done` are 0 and every bank word read through `rd_data` is zero.
- R2: Accepted sample n of a frame (counting from 0) is stored in bank n mod 8 at row n div 8. The stored word is {I, Q}, with I in bits [15:8]. Bank b appears on `rd_data[16*b+15:16*b]` in the same cycle that `rd_addr` selects the row, with no clock edge needed.
- R3: Mode codes 2'b00, 2'b10 and 2'b11 select a 128-sample frame. `frame_ready` is high for exactly one cycle, the cycle after the edge that stores sample 127, with `frame_short` = 0. At no other time is it high.
- R4: Mode code 2'b01 selects a 32-sample frame. `frame_ready` is high for one cycle after the edge that stores sample 31, with `frame_short` = 1.
- R5: The frame length comes from the value of `mode_sel` in the cycle before the first sample of the frame. Values of `mode_sel` during the first sample or any later sample of that frame have no effect on it.
- R6: A new frame may begin on the cycle right after the last sample of the previous one. Its mode is the `mode_sel` value present during that last sample.
- R7: Cycles with `wr_valid` low inside a frame store nothing and do not advance the sample count.
- R8: A `clear` pulse while idle sets `clear_busy` for exactly 16 cycles. It zeroes all rows of all banks, and `clear_done` is high only in the 16th of those cycles. It also discards any partial frame, so the next frame starts at sample 0.
- R9: Samples offered while `clear_busy` is high, or in the same cycle as an accepted `clear`, are not stored and never produce `frame_ready`.
- R10: A `clear` pulse while `clear_busy` is high is ignored and does not extend the task.
- R11: A `kill` pulse stops everything on the next edge. After it, `clear_busy` and `frame_ready` are 0, a running clear stops zeroing at once, a `clear` in the same cycle does not start, a sample in the same cycle is dropped, and a partial frame is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, also zeroes the banks |
| kill | input | 1 | Synchronous abort of all control state |
| clear | input | 1 | Start pulse for the bank-zeroing task |
| mode_sel | input | 2 | Frame length code, 2'b01 short, others long |
| wr_valid | input | 1 | Sample strobe |
| din_i | input | 8 | In-phase sample |
| din_q | input | 8 | Quadrature sample |
| rd_addr | input | 4 | Engine read row, shared by all banks |
| rd_data | output | 128 | Eight bank words, bank b in bits [16b+15:16b] |
| frame_ready | output | 1 | One-cycle frame complete pulse |
| frame_short | output | 1 | Qualifies `frame_ready`: 1 for a 32-sample frame |
| clear_busy | output | 1 | Zeroing task running |
| clear_done | output | 1 | Last cycle of the zeroing task |

## Verification
Frames are driven with each sample's value built from a seed and its index, so a word stored at the wrong bank or row shows up on read-back. Every ordered pair of the four mode codes is sent back to back, with stray mode values placed on the first and middle samples. This separates a design that samples the mode a cycle early from one that samples it with the data, and it catches any reserved code that is taken as short. Strobes with idle gaps separate counting accepted samples from counting cycles. Clear and kill are applied over partial frames, during a running clear and in the same cycle as each other. The stored rows then show exactly which writes each task let through.

// File: rtl/inbuf_pkg.sv
package inbuf_pkg;

    typedef enum logic [1:0] {
        MODE_LONG   = 2'b00,
        MODE_SHORT  = 2'b01,
        MODE_LONG_B = 2'b10,
        MODE_LONG_C = 2'b11
    } xf_mode_e;

    typedef enum logic {
        ZS_IDLE = 1'b0,
        ZS_RUN  = 1'b1
    } zero_state_e;

    function automatic logic mode_is_short(xf_mode_e m);
        return m == MODE_SHORT;
    endfunction

    function automatic int unsigned frame_last(xf_mode_e m, int unsigned long_len,
                                               int unsigned short_len);
        return mode_is_short(m) ? short_len - 1 : long_len - 1;
    endfunction

endpackage

// File: rtl/inbuf_bank.sv
module inbuf_bank #(
    parameter int DEPTH = 16,
    parameter int DW    = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [DW-1:0]            rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/inbuf_seq.sv
module inbuf_seq
    import inbuf_pkg::*;
#(
    parameter int NBANK     = 8,
    parameter int DEPTH     = 16,
    parameter int LONG_LEN  = 128,
    parameter int SHORT_LEN = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     kill,
    input  logic                     flush,
    input  logic                     accept,
    input  logic [1:0]               mode_sel,
    output logic [$clog2(NBANK)-1:0] bank_sel,
    output logic [$clog2(DEPTH)-1:0] row_sel,
    output logic                     ready,
    output logic                     ready_short
);
    localparam int TOTAL = NBANK * DEPTH;
    localparam int CW    = $clog2(TOTAL);
    localparam int BW    = $clog2(NBANK);

    logic [CW-1:0] cnt;
    xf_mode_e      mode_prev, mode_frame, cur_mode;
    logic          cur_short, at_last;

    assign cur_mode  = (cnt == '0) ? mode_prev : mode_frame;
    assign cur_short = mode_is_short(cur_mode);
    assign at_last   = cnt == CW'(frame_last(cur_mode, LONG_LEN, SHORT_LEN));
    assign bank_sel  = cnt[BW-1:0];
    assign row_sel   = cnt[CW-1:BW];

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            cnt         <= '0;
            mode_prev   <= MODE_LONG;
            mode_frame  <= MODE_LONG;
            ready       <= 1'b0;
            ready_short <= 1'b0;
        end else begin
            mode_prev   <= xf_mode_e'(mode_sel);
            ready       <= 1'b0;
            ready_short <= 1'b0;
            if (flush) begin
                cnt <= '0;
            end else if (accept) begin
                if (cnt == '0) mode_frame <= mode_prev;
                cnt         <= at_last ? '0 : cnt + CW'(1);
                ready       <= at_last;
                ready_short <= at_last & cur_short;
            end
        end
    end
endmodule

// File: rtl/inbuf_zero.sv
module inbuf_zero
    import inbuf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     kill,
    input  logic                     clear,
    output logic                     busy,
    output logic                     done,
    output logic [$clog2(DEPTH)-1:0] row
);
    localparam int AW = $clog2(DEPTH);

    zero_state_e state;

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            state <= ZS_IDLE;
            row   <= '0;
        end else begin
            case (state)
                ZS_IDLE: begin
                    row <= '0;
                    if (clear) state <= ZS_RUN;
                end
                ZS_RUN: begin
                    row <= row + AW'(1);
                    if (row == AW'(DEPTH - 1)) state <= ZS_IDLE;
                end
                default: state <= ZS_IDLE;
            endcase
        end
    end

    assign busy = state == ZS_RUN;
    assign done = busy && (row == AW'(DEPTH - 1));
endmodule

// File: rtl/xfrm_inbuf.sv
module xfrm_inbuf #(
    parameter int SAMP_W    = 8,
    parameter int NBANK     = 8,
    parameter int DEPTH     = 16,
    parameter int LONG_LEN  = 128,
    parameter int SHORT_LEN = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          kill,
    input  logic                          clear,
    input  logic [1:0]                    mode_sel,
    input  logic                          wr_valid,
    input  logic [SAMP_W-1:0]             din_i,
    input  logic [SAMP_W-1:0]             din_q,
    input  logic [$clog2(DEPTH)-1:0]      rd_addr,
    output logic [NBANK*2*SAMP_W-1:0]     rd_data,
    output logic                          frame_ready,
    output logic                          frame_short,
    output logic                          clear_busy,
    output logic                          clear_done
);
    localparam int AW = $clog2(DEPTH);
    localparam int BW = $clog2(NBANK);
    localparam int DW = 2 * SAMP_W;

    typedef struct packed {
        logic          en;
        logic [AW-1:0] row;
        logic [DW-1:0] data;
    } bank_wr_t;

    logic          zero_busy, zero_done;
    logic [AW-1:0] zero_row;
    logic [BW-1:0] seq_bank;
    logic [AW-1:0] seq_row;
    logic          accept, flush, zeroing;

    // priority: kill, then clear (start or running), then sample writes
    assign accept  = wr_valid & ~kill & ~clear & ~zero_busy;
    assign flush   = clear | zero_busy;
    assign zeroing = zero_busy & ~kill;

    inbuf_zero #(.DEPTH(DEPTH)) u_zero (
        .clk   (clk),
        .rst   (rst),
        .kill  (kill),
        .clear (clear),
        .busy  (zero_busy),
        .done  (zero_done),
        .row   (zero_row)
    );

    inbuf_seq #(
        .NBANK     (NBANK),
        .DEPTH     (DEPTH),
        .LONG_LEN  (LONG_LEN),
        .SHORT_LEN (SHORT_LEN)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .kill        (kill),
        .flush       (flush),
        .accept      (accept),
        .mode_sel    (mode_sel),
        .bank_sel    (seq_bank),
        .row_sel     (seq_row),
        .ready       (frame_ready),
        .ready_short (frame_short)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        bank_wr_t      cmd;
        logic [DW-1:0] word;

        always_comb begin
            cmd = '0;
            if (zeroing) begin
                cmd.en  = 1'b1;
                cmd.row = zero_row;
            end else if (accept && seq_bank == BW'(b)) begin
                cmd.en   = 1'b1;
                cmd.row  = seq_row;
                cmd.data = {din_i, din_q};
            end
        end

        inbuf_bank #(.DEPTH(DEPTH), .DW(DW)) u_bank (
            .clk   (clk),
            .rst   (rst),
            .we    (cmd.en),
            .waddr (cmd.row),
            .wdata (cmd.data),
            .raddr (rd_addr),
            .rdata (word)
        );

        assign rd_data[b*DW +: DW] = word;
    end

    assign clear_busy = zero_busy;
    assign clear_done = zero_done;
endmodule

// File: rtl/inbuf_chk.sv
module inbuf_chk #(
    parameter int DEPTH = 16
) (
    input logic clk,
    input logic rst,
    input logic kill,
    input logic clear,
    input logic wr_valid,
    input logic frame_ready,
    input logic clear_busy,
    input logic clear_done
);
    localparam int RW = $clog2(DEPTH) + 1;

    logic [RW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) run_cnt <= '0;
        else     run_cnt <= clear_busy ? run_cnt + RW'(1) : '0;
    end

    assert_ready_after_write_R3: assert property (@(posedge clk) disable iff (rst)
        frame_ready |-> $past(wr_valid));

    assert_ready_single_R6: assert property (@(posedge clk) disable iff (rst)
        frame_ready |=> !frame_ready);

    assert_clear_starts_R8: assert property (@(posedge clk) disable iff (rst)
        (clear && !clear_busy && !kill) |=> clear_busy);

    assert_busy_bound_R8: assert property (@(posedge clk) disable iff (rst)
        clear_busy |-> (run_cnt < RW'(DEPTH)));

    assert_done_on_last_R8: assert property (@(posedge clk) disable iff (rst)
        clear_done |-> (clear_busy && run_cnt == RW'(DEPTH - 1)));

    assert_done_then_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (clear_done && !kill) |=> !clear_busy);

    assert_no_ready_in_clear_R9: assert property (@(posedge clk) disable iff (rst)
        clear_busy |-> !frame_ready);

    assert_kill_idles_R11: assert property (@(posedge clk) disable iff (rst)
        kill |=> (!clear_busy && !frame_ready && !clear_done));
endmodule

bind xfrm_inbuf inbuf_chk #(.DEPTH(DEPTH)) u_inbuf_chk (
    .clk         (clk),
    .rst         (rst),
    .kill        (kill),
    .clear       (clear),
    .wr_valid    (wr_valid),
    .frame_ready (frame_ready),
    .clear_busy  (clear_busy),
    .clear_done  (clear_done)
);

// File: tb/tb_xfrm_inbuf.sv
`timescale 1ns/1ps
module tb_xfrm_inbuf;
    localparam int NB = 8;
    localparam int DP = 16;
    localparam int LL = 128;
    localparam int SL = 32;

    logic         clk = 1'b0;
    logic         rst, kill, clear, wr_valid;
    logic [1:0]   mode_sel;
    logic [7:0]   din_i, din_q;
    logic [3:0]   rd_addr;
    logic [127:0] rd_data;
    logic         frame_ready, frame_short, clear_busy, clear_done;

    int    checks = 0;
    int    fails  = 0;
    logic  pend_ready = 1'b0;
    logic  pend_short = 1'b0;
    string pend_tag   = "R3 no stray ready";
    logic [15:0] exp_mem [NB][DP];

    always #5 clk = ~clk;

    xfrm_inbuf dut (
        .clk(clk), .rst(rst), .kill(kill), .clear(clear), .mode_sel(mode_sel),
        .wr_valid(wr_valid), .din_i(din_i), .din_q(din_q), .rd_addr(rd_addr),
        .rd_data(rd_data), .frame_ready(frame_ready), .frame_short(frame_short),
        .clear_busy(clear_busy), .clear_done(clear_done)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] gen_i(int s, int n);
        return 8'(s * 7 + n * 13 + 3);
    endfunction

    function automatic logic [7:0] gen_q(int s, int n);
        return 8'(s * 31 + n * 29 + 91);
    endfunction

    // one clock: check the pulse expected from the previous edge, then drive
    task automatic tick(input logic w, input logic [7:0] i, input logic [7:0] q,
                        input logic [1:0] m, input logic c, input logic k);
        @(negedge clk);
        chk(pend_tag, {frame_ready, frame_ready & frame_short},
                      {pend_ready, pend_ready & pend_short});
        pend_ready = 1'b0;
        pend_short = 1'b0;
        pend_tag   = "R3 no stray ready";
        wr_valid = w; din_i = i; din_q = q; mode_sel = m; clear = c; kill = k;
    endtask

    task automatic idle(input logic [1:0] m);
        tick(1'b0, 8'h00, 8'h00, m, 1'b0, 1'b0);
    endtask

    // fm: frame mode (already on mode_sel the cycle before), m0: mode driven
    // with sample 0, mlast: mode driven with the last sample, cut: partial length
    task automatic send_frame(input logic [1:0] fm, input logic [1:0] m0,
                              input logic [1:0] mlast, input int seed, input int gap,
                              input int cut, input string tag);
        int full = (fm == 2'b01) ? SL : LL;
        int len  = (cut > 0) ? cut : full;
        for (int n = 0; n < len; n++) begin
            logic [1:0] m;
            if (gap > 0 && n > 0 && (n % gap) == 0)
                tick(1'b0, 8'hEE, 8'hEE, 2'(n), 1'b0, 1'b0);
            m = (n == 0) ? m0 : ((n == full - 1) ? mlast : 2'(n * 3));
            tick(1'b1, gen_i(seed, n), gen_q(seed, n), m, 1'b0, 1'b0);
            exp_mem[n % NB][n / NB] = {gen_i(seed, n), gen_q(seed, n)};
            if (n == full - 1) begin
                pend_ready = 1'b1;
                pend_short = (fm == 2'b01);
                pend_tag   = tag;
            end
        end
    endtask

    task automatic check_mem(input string tag);
        for (int a = 0; a < DP; a++) begin
            rd_addr = 4'(a);
            #1;
            for (int b = 0; b < NB; b++)
                chk(tag, 128'(rd_data[b*16 +: 16]), 128'(exp_mem[b][a]));
        end
    endtask

    initial begin
        #2_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; kill = 1'b0; clear = 1'b0; wr_valid = 1'b0;
        mode_sel = 2'b00; din_i = '0; din_q = '0; rd_addr = '0;
        for (int b = 0; b < NB; b++)
            for (int a = 0; a < DP; a++) exp_mem[b][a] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 ready", frame_ready, 0);
        chk("R1 short", frame_short, 0);
        chk("R1 busy", clear_busy, 0);
        chk("R1 done", clear_done, 0);
        check_mem("R1 banks zero");

        // R3 / R4 basic frames, R2 mapping
        idle(2'b00);
        send_frame(2'b00, 2'b00, 2'b00, 1, 0, 0, "R3 long frame ready");
        idle(2'b00);
        check_mem("R2 long frame mapping");
        idle(2'b01);
        send_frame(2'b01, 2'b01, 2'b01, 2, 0, 0, "R4 short frame ready");
        idle(2'b01);
        check_mem("R2 short frame mapping");

        // R5 mode taken from the cycle before the first sample
        idle(2'b01);
        send_frame(2'b01, 2'b00, 2'b01, 3, 0, 0, "R5 short kept despite change");
        idle(2'b00);
        send_frame(2'b00, 2'b01, 2'b01, 4, 0, 0, "R5 long kept despite change");
        idle(2'b00);
        check_mem("R5 mapping");

        // R6 every ordered pair of mode codes back to back
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                idle(2'(a));
                send_frame(2'(a), 2'(a + 1), 2'(b), 10 + a * 4 + b, 0, 0, "R6 first frame");
                send_frame(2'(b), 2'(b + 2), 2'(a), 40 + a * 4 + b, 0, 0, "R6 second frame");
                idle(2'b00);
                check_mem("R6 back-to-back mapping");
            end
        end

        // R7 strobe gaps
        idle(2'b01);
        send_frame(2'b01, 2'b01, 2'b00, 50, 3, 0, "R7 gapped short");
        idle(2'b00);
        send_frame(2'b00, 2'b00, 2'b00, 51, 5, 0, "R7 gapped long");
        idle(2'b00);
        check_mem("R7 gapped mapping");

        // R8 / R9 / R10 clear task over a partial frame
        idle(2'b01);
        send_frame(2'b01, 2'b01, 2'b01, 60, 0, 5, "R8 partial");
        tick(1'b1, 8'hAA, 8'hBB, 2'b01, 1'b1, 1'b0);   // clear beats write (R9)
        for (int j = 0; j < DP; j++) begin
            tick(1'b1, gen_i(99, j), gen_q(99, j), 2'b01, (j == 4), 1'b0);
            chk("R8 busy during clear", clear_busy, 1);
            chk("R10 done only on 16th cycle", clear_done, (j == DP - 1));
        end
        idle(2'b01);
        chk("R8 busy ends after 16", clear_busy, 0);
        chk("R8 done ends", clear_done, 0);
        for (int b = 0; b < NB; b++)
            for (int a = 0; a < DP; a++) exp_mem[b][a] = '0;
        check_mem("R9 banks zero, writes ignored");
        send_frame(2'b01, 2'b01, 2'b01, 61, 0, 0, "R8 frame restarts at sample 0");
        idle(2'b01);
        check_mem("R8 mapping after clear");

        // R11 kill over a partial frame
        idle(2'b01);
        send_frame(2'b01, 2'b01, 2'b01, 70, 0, 10, "R11 partial");
        tick(1'b1, 8'h55, 8'h66, 2'b01, 1'b0, 1'b1);
        idle(2'b01);
        chk("R11 busy after kill", clear_busy, 0);
        send_frame(2'b01, 2'b01, 2'b01, 71, 0, 0, "R11 count restarts after kill");
        idle(2'b01);
        check_mem("R11 mapping after kill");

        // R11 kill during clear stops zeroing after three rows
        tick(1'b0, 8'h00, 8'h00, 2'b01, 1'b1, 1'b0);
        for (int j = 0; j < 4; j++)
            tick(1'b0, 8'h00, 8'h00, 2'b01, 1'b0, (j == 3));
        idle(2'b01);
        chk("R11 busy dropped by kill", clear_busy, 0);
        chk("R11 done dropped by kill", clear_done, 0);
        for (int b = 0; b < NB; b++)
            for (int a = 0; a < 3; a++) exp_mem[b][a] = '0;
        check_mem("R11 zeroing halted by kill");

        // R11 kill and clear together
        tick(1'b0, 8'h00, 8'h00, 2'b01, 1'b1, 1'b1);
        idle(2'b01);
        chk("R11 kill beats clear", clear_busy, 0);
        idle(2'b01);
        chk("R11 still idle", clear_busy, 0);
        check_mem("R11 banks untouched");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule